// File: doc/BRIEF.md
# Scrambled-Map 64-Source Interrupt Controller

This block gathers 64 active-low interrupt lines into one request output. Each line passes through a synchroniser and then either a level detector or a falling-edge detector, and sets a per-source pending flag. Software reads and writes five registers on a simple synchronous bus: two mask words, two pending words and a sense-select word. It also reads a vector register that names the pending, enabled source with the lowest number.

Sources do not sit at the bit whose index equals their number. A fixed table spreads them over a "high" word and a "low" word in a scrambled order, and both the mask and pending registers use that table. Pending flags of edge-mode sources are cleared by writing 1 to their bit. Only two groups of sources can be switched to edge mode. Every other source is always level-low.

Top module: `intc64`

## Requirements
- R1: After reset, both mask words, both pending words and the sense-select word read 0, `irq` is low and the vector reads 0.
- R2: The register addresses are: 0 mask-high, 1 mask-low, 2 pending-high, 3 pending-low, 4 vector (read-only), 5 sense-select. Addresses 6 and 7 read 0, and writes to 4, 6 and 7 change nothing. Mask words read back what was written.
- R3: Source s sits in the high word when s/16 is even and in the low word otherwise. Its bit within that word is: s=0 → 0; s in 1..15 → 16−s; s in 16..18 → 18−s; s in 19..30 → 33−s; s=31 → 15; s in 32..47 → 63−s; s in 48..63 → s−32.
- R4: A level-mode source's pending bit equals the inverse of its input, delayed by three clock edges: two synchroniser flops, then the pending flop.
- R5: An edge-mode source's pending bit is set by a high-to-low input transition, with the same three-edge latency. A rising transition does not set it. The bit then holds until a 1 is written to it. Writing 0 leaves it set.
- R6: Write-1-clear has no lasting effect on a level-mode source; its bit keeps following the input. If a falling edge and a clear arrive in the same cycle, the edge wins.
- R7: Sense-select bit 33−s chooses falling-edge mode for sources 19..25, and bit 79−s does so for sources 48..63. A 1 selects falling edge and a 0 selects level-low. All other bits of the word ignore writes and read 0.
- R8: `irq` is high exactly when at least one source has both its pending bit and its mask bit (1 = enabled) set.
- R9: The vector register returns, in bits 31:26, the lowest-numbered source that is pending and enabled. It returns 0 when there is none; its other bits are 0.
- R10: Source 0 is reserved. Its pending bit never sets, whatever its input does.
- R11: Masking does not affect pending state. A disabled source still shows in its pending word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 3 | Register address |
| bus_we | input | 1 | Write strobe, sampled at the clock edge |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from address |
| src_n | input | 64 | Raw active-low interrupt lines, asynchronous |
| irq | output | 1 | Interrupt request to the processor |

## Verification
The hardest case to reach from the ports is the interplay between an edge-mode pending flag and changes of mode or clears. Examples are a source switched from level to edge while its line is held low, and a clear written while the line stays low after its edge. The stimulus reaches these cases by mixing random writes of the sense-select word with random line flips and random write-1-clear words. A bench model tracks, source by source, whether each flag must hold, follow the line or drop. Directed steps also walk one low line across all 64 sources to pin down the scrambled table, and they sample the pending word on the exact edges around the three-edge latency.

// File: rtl/intc_pkg.sv
package intc_pkg;
    localparam int NSRC     = 64;
    localparam int WORD_W   = 32;
    localparam int BIT_W    = $clog2(WORD_W);
    localparam int SRC_W    = $clog2(NSRC);
    localparam logic [WORD_W-1:0] SENSE_WMASK = 32'hFFFF_7F00;

    typedef enum logic [2:0] {
        RA_MASK_HI = 3'd0,
        RA_MASK_LO = 3'd1,
        RA_PEND_HI = 3'd2,
        RA_PEND_LO = 3'd3,
        RA_VECTOR  = 3'd4,
        RA_SENSE   = 3'd5
    } reg_addr_e;

    // word select for a source: 1 = high word
    function automatic logic src_in_hi(int s);
        return (s < 16) || (s >= 32 && s < 48);
    endfunction

    // bit position of a source inside its word
    function automatic logic [BIT_W-1:0] src_bit(int s);
        int b;
        if (s == 0)       b = 0;
        else if (s < 16)  b = 16 - s;
        else if (s < 19)  b = 18 - s;
        else if (s < 31)  b = 33 - s;
        else if (s == 31) b = 15;
        else if (s < 48)  b = 63 - s;
        else              b = s - 32;
        return b[BIT_W-1:0];
    endfunction

    function automatic logic src_has_sense(int s);
        return (s >= 19 && s <= 25) || (s >= 48 && s <= 63);
    endfunction

    function automatic logic [BIT_W-1:0] sense_bit(int s);
        int b;
        b = (s <= 25) ? (33 - s) : (79 - s);
        return b[BIT_W-1:0];
    endfunction
endpackage

// File: rtl/intc_sense.sv
module intc_sense #(
    parameter int N      = 64,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] raw_n,
    output logic [N-1:0] low_now,
    output logic [N-1:0] fell
);
    // chain[0..STAGES-1] synchronise, chain[STAGES] keeps the previous value
    logic [N-1:0] chain [STAGES+1];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i <= STAGES; i++) chain[i] <= '1;
        end else begin
            chain[0] <= raw_n;
            for (int i = 1; i <= STAGES; i++) chain[i] <= chain[i-1];
        end
    end

    assign low_now = ~chain[STAGES-1];
    assign fell    = chain[STAGES] & ~chain[STAGES-1];
endmodule

// File: rtl/intc_pending.sv
module intc_pending #(
    parameter int N        = 64,
    parameter int RESERVED = 0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] low_now,
    input  logic [N-1:0] fell,
    input  logic [N-1:0] edge_mode,
    input  logic [N-1:0] clr,
    output logic [N-1:0] pend
);
    for (genvar s = 0; s < N; s++) begin : g_src
        if (s == RESERVED) begin : g_rsv
            assign pend[s] = 1'b0;
        end else begin : g_live
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)            pend[s] <= 1'b0;
                else if (edge_mode[s]) pend[s] <= fell[s] | (pend[s] & ~clr[s]);
                else                   pend[s] <= low_now[s];
            end

            a_r5_edge_holds: assert property (@(posedge clk) disable iff (!rst_n)
                (edge_mode[s] && pend[s] && !clr[s]) |=> pend[s]);
            a_r5_w1c_clears: assert property (@(posedge clk) disable iff (!rst_n)
                (edge_mode[s] && clr[s] && !fell[s]) |=> !pend[s]);
            a_r6_edge_beats_clear: assert property (@(posedge clk) disable iff (!rst_n)
                (edge_mode[s] && fell[s]) |=> pend[s]);
            a_r5_no_spurious_set: assert property (@(posedge clk) disable iff (!rst_n)
                (edge_mode[s] && !pend[s] && !fell[s]) |=> !pend[s]);
        end
    end
endmodule

// File: rtl/intc_prio.sv
module intc_prio #(
    parameter int N     = 64,
    parameter int IDX_W = $clog2(N)
) (
    input  logic [N-1:0]     req,
    output logic             any,
    output logic [IDX_W-1:0] idx
);
    always_comb begin
        idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) idx = IDX_W'(i);
        end
    end
    assign any = |req;
endmodule

// File: rtl/intc64.sv
module intc64
    import intc_pkg::*;
#(
    parameter int ADDR_W      = 3,
    parameter int SYNC_STAGES = 2,
    parameter int VEC_LSB     = 26
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    input  logic [63:0]       src_n,
    output logic              irq
);
    logic [WORD_W-1:0] mask_hi, mask_lo, sense_q;
    logic [WORD_W-1:0] pend_hi, pend_lo;
    logic [NSRC-1:0]   low_now, fell, edge_mode, clr, pend, mask_src;
    logic [SRC_W-1:0]  vec_idx;

    wire wr_mask_hi = bus_we && (bus_addr == ADDR_W'(RA_MASK_HI));
    wire wr_mask_lo = bus_we && (bus_addr == ADDR_W'(RA_MASK_LO));
    wire wr_pend_hi = bus_we && (bus_addr == ADDR_W'(RA_PEND_HI));
    wire wr_pend_lo = bus_we && (bus_addr == ADDR_W'(RA_PEND_LO));
    wire wr_sense   = bus_we && (bus_addr == ADDR_W'(RA_SENSE));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mask_hi <= '0;
            mask_lo <= '0;
            sense_q <= '0;
        end else begin
            if (wr_mask_hi) mask_hi <= bus_wdata;
            if (wr_mask_lo) mask_lo <= bus_wdata;
            if (wr_sense)   sense_q <= bus_wdata & SENSE_WMASK;
        end
    end

    // scatter word state to sources and gather pending back into words
    always_comb begin
        pend_hi = '0;
        pend_lo = '0;
        for (int s = 0; s < NSRC; s++) begin
            if (src_in_hi(s)) begin
                mask_src[s]           = mask_hi[src_bit(s)];
                clr[s]                = wr_pend_hi && bus_wdata[src_bit(s)];
                pend_hi[src_bit(s)]   = pend[s];
            end else begin
                mask_src[s]           = mask_lo[src_bit(s)];
                clr[s]                = wr_pend_lo && bus_wdata[src_bit(s)];
                pend_lo[src_bit(s)]   = pend[s];
            end
            edge_mode[s] = src_has_sense(s) ? sense_q[sense_bit(s)] : 1'b0;
        end
    end

    intc_sense #(.N(NSRC), .STAGES(SYNC_STAGES)) u_sense (
        .clk    (clk),
        .rst_n  (rst_n),
        .raw_n  (src_n),
        .low_now(low_now),
        .fell   (fell)
    );

    intc_pending #(.N(NSRC), .RESERVED(0)) u_pend (
        .clk      (clk),
        .rst_n    (rst_n),
        .low_now  (low_now),
        .fell     (fell),
        .edge_mode(edge_mode),
        .clr      (clr),
        .pend     (pend)
    );

    intc_prio #(.N(NSRC), .IDX_W(SRC_W)) u_prio (
        .req(pend & mask_src),
        .any(irq),
        .idx(vec_idx)
    );

    always_comb begin
        unique case (bus_addr)
            ADDR_W'(RA_MASK_HI): bus_rdata = mask_hi;
            ADDR_W'(RA_MASK_LO): bus_rdata = mask_lo;
            ADDR_W'(RA_PEND_HI): bus_rdata = pend_hi;
            ADDR_W'(RA_PEND_LO): bus_rdata = pend_lo;
            ADDR_W'(RA_VECTOR):  bus_rdata = 32'(vec_idx) << VEC_LSB;
            ADDR_W'(RA_SENSE):   bus_rdata = sense_q;
            default:             bus_rdata = '0;
        endcase
    end

    a_r9_idle_vector_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !irq |-> (vec_idx == '0));
    a_r9_busy_vector_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (vec_idx != '0));
    a_r10_reserved_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !pend_hi[0]);
    a_r7_sense_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
        wr_sense |=> ((sense_q & ~SENSE_WMASK) == '0));
endmodule

// File: tb/tb_intc64.sv
`timescale 1ns/1ps
module tb_intc64;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  bus_addr = '0;
    logic        bus_we = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [63:0] src_n = '1;
    logic        irq;

    int checks = 0;
    int fails  = 0;

    logic [63:0] exp_pend = '0;
    logic [31:0] exp_mhi = '0, exp_mlo = '0, exp_sense = '0;

    always #2 clk = ~clk;

    intc64 dut (.clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
                .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .src_n(src_n), .irq(irq));

    function automatic bit b_hi(int s);
        return ((s / 16) % 2) == 0;
    endfunction

    function automatic int b_bit(int s);
        case (s / 16)
            0:       return (s == 0) ? 0 : 16 - s;
            1:       return (s == 31) ? 15 : ((s < 19) ? 18 - s : 33 - s);
            2:       return 63 - s;
            default: return s - 32;
        endcase
    endfunction

    function automatic bit b_edge(int s);
        if (s >= 19 && s <= 25) return exp_sense[14 - (s - 19)];
        if (s >= 48)            return exp_sense[31 - (s - 48)];
        return 1'b0;
    endfunction

    function automatic logic [31:0] b_word(logic [63:0] v, bit hi);
        logic [31:0] w = '0;
        for (int s = 0; s < 64; s++) if (b_hi(s) == hi) w[b_bit(s)] = v[s];
        return w;
    endfunction

    function automatic int b_vec();
        for (int s = 1; s < 64; s++) begin
            bit m = b_hi(s) ? exp_mhi[b_bit(s)] : exp_mlo[b_bit(s)];
            if (exp_pend[s] && m) return s;
        end
        return 0;
    endfunction

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_we = 1'b1;
        @(negedge clk);
        bus_we = 1'b0;
        case (a)
            3'd0: exp_mhi = d;
            3'd1: exp_mlo = d;
            3'd2, 3'd3:
                for (int s = 1; s < 64; s++)
                    if (b_edge(s) && b_hi(s) == (a == 3'd2) && d[b_bit(s)]) exp_pend[s] = 1'b0;
            3'd5: begin
                exp_sense = d & 32'hFFFF_7F00;
                for (int s = 1; s < 64; s++) if (!b_edge(s)) exp_pend[s] = ~src_n[s];
            end
            default: ;
        endcase
    endtask

    task automatic drive(input logic [63:0] nv);
        logic [63:0] pv = src_n;
        @(negedge clk);
        src_n = nv;
        repeat (4) @(negedge clk);
        for (int s = 1; s < 64; s++) begin
            if (b_edge(s)) begin
                if (pv[s] && !nv[s]) exp_pend[s] = 1'b1;
            end else exp_pend[s] = ~nv[s];
        end
    endtask

    task automatic check_all(string tag);
        logic [31:0] d;
        repeat (2) @(negedge clk);
        rd(3'd0, d); chk({tag, " R2 mask-high"}, d, exp_mhi);
        rd(3'd1, d); chk({tag, " R2 mask-low"}, d, exp_mlo);
        rd(3'd2, d); chk({tag, " R11 pend-high"}, d, b_word(exp_pend, 1'b1));
        rd(3'd3, d); chk({tag, " R11 pend-low"}, d, b_word(exp_pend, 1'b0));
        rd(3'd4, d); chk({tag, " R9 vector"}, d, 32'(b_vec()) << 26);
        rd(3'd5, d); chk({tag, " R7 sense"}, d, exp_sense);
        chk({tag, " R8 irq"}, 32'(irq), 32'(b_vec() != 0));
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired act=running exp=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        logic [31:0] d;
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        check_all("R1 reset");

        // R3 walk one low line; masks zero so R11 and R8 also apply
        for (int s = 0; s < 64; s++) begin
            drive(~(64'd1 << s));
            rd(b_hi(s) ? 3'd2 : 3'd3, d);
            chk($sformatf("R3 src %0d own word", s), d, (s == 0) ? 32'd0 : (32'd1 << b_bit(s)));
            rd(b_hi(s) ? 3'd3 : 3'd2, d);
            chk($sformatf("R3 src %0d other word", s), d, 32'd0);
            if (s == 0) check_all("R10 reserved");
            drive('1);
        end

        // R4 exact latency on level source 7 (high word bit 9)
        @(negedge clk); bus_addr = 3'd2;
        src_n[7] = 1'b0;
        @(negedge clk); #1 chk("R4 after 1 edge", bus_rdata, 32'd0);
        @(negedge clk); #1 chk("R4 after 2 edges", bus_rdata, 32'd0);
        @(negedge clk); #1 chk("R4 after 3 edges", bus_rdata, 32'd1 << 9);
        exp_pend[7] = 1'b1;
        drive('1);

        // R9 priority
        wr(3'd0, '1); wr(3'd1, '1);
        drive(~((64'd1 << 40) | (64'd1 << 20)));
        check_all("R9 two sources");
        drive(~(64'd1 << 40));
        check_all("R9 one left");
        wr(3'd0, ~(32'd1 << 23));
        check_all("R8 masked off");
        drive('1);

        // R7 sense write mask, R5 edge on source 50 (low bit 18) and 22
        wr(3'd5, '1);
        check_all("R7 sense readback");
        drive(~(64'd1 << 50)); drive('1);
        check_all("R5 edge held after rise");
        wr(3'd3, 32'd0);
        check_all("R5 write 0 keeps");
        wr(3'd3, 32'd1 << 18);
        check_all("R5 w1c clears");
        drive(~(64'd1 << 22));
        wr(3'd3, 32'd1 << 11);
        check_all("R5 clear while low");
        drive('1);
        check_all("R5 rise no set");

        // R6 level source ignores w1c
        wr(3'd5, 32'd0);
        drive(~(64'd1 << 5));
        wr(3'd2, 32'd1 << 11);
        check_all("R6 level w1c");
        drive('1);

        // R2 empty addresses and read-only vector
        wr(3'd4, '1); wr(3'd6, '1); wr(3'd7, '1);
        rd(3'd6, d); chk("R2 addr 6", d, 32'd0);
        rd(3'd7, d); chk("R2 addr 7", d, 32'd0);
        check_all("R2 after dead writes");

        // random phase
        for (int it = 0; it < 200; it++) begin
            case ($urandom % 4)
                0: drive(src_n ^ {$urandom & $urandom & $urandom, $urandom & $urandom & $urandom});
                1: wr(3'(($urandom % 2)), $urandom);
                2: wr(3'(2 + ($urandom % 2)), $urandom);
                default: wr(3'd5, $urandom);
            endcase
            check_all("R5/R6/R9 random");
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule